// File: doc/BRIEF.md
# Dual-Clock Buffer with One-Shot Start-Read Strobe

This block carries 10-bit words from a write clock domain, typically fed by a deserializer, into an unrelated read clock domain. It stores up to 15 words. Each domain keeps its own binary pointer. The pointers cross to the other domain as Gray code through two-flop synchronizers. The write side raises `full` and the read side raises `empty`. The block relies on its user to respect these flags. A write attempted while full is dropped, and a read attempted while empty is dropped.

An active-low start-read strobe is timed on the write clock. It tells the consumer that enough words have built up to begin reading. After any reset the strobe is armed. It goes low one write edge after the write-side occupancy reaches five. It goes high again one write edge after the occupancy reaches six. It then stays high until the next reset. Read progress reaches the write side only through the synchronizer, so reads that start early can delay the strobe or lengthen its low time.

Three active-low reset inputs (power-on, buffer-local and global) are combined. Any one of them empties the buffer and re-arms the strobe. Reset takes effect at once and is released in step with each clock.

Top module: `xclk_startbuf`

## Requirements
- R1: While any reset is held and after its release, `empty`=1, `full`=0, `start_rd_n`=1 and `rdata`=0 until the first accepted write or read.
- R2: Words are read out in the order they were written, unchanged, across the two clock domains. The read word appears on `rdata` at the read-clock edge that accepts the read.
- R3: After 15 writes with no read, `full` is 1 right after the 15th accepting write edge. A further write is discarded: it neither changes the stored words nor their order.
- R4: `empty` returns to 1 once every stored word has been read. A read while `empty`=1 is discarded: `rdata` holds, and the next written word is the next one read.
- R5: With the strobe armed, `start_rd_n` goes to 0 at the first write edge at which the write-side occupancy is already 5 or more. It stays 0 while the occupancy remains 5.
- R6: `start_rd_n` returns to 1 at the first write edge at which the write-side occupancy is already 6 or more. Under back-to-back writes it is therefore low for exactly one write cycle, the cycle after the 6th write.
- R7: Once `start_rd_n` has returned to 1, it stays 1 until a reset. This holds even if the buffer is drained and refilled.
- R8: Driving any one of `por_n`, `buf_rst_n` or `glob_rst_n` low empties the buffer, clears `full`, sets `start_rd_n` to 1 and re-arms the strobe.
- R9: `rdata` changes only at a read-clock edge where `rd_en`=1 and `empty`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write request, sampled on rising `wclk` |
| wdata | input | 10 | Word to store |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request, sampled on rising `rclk` |
| por_n | input | 1 | Power-on reset, active low |
| buf_rst_n | input | 1 | Buffer-local reset, active low |
| glob_rst_n | input | 1 | Global reset, active low |
| rdata | output | 10 | Registered read word |
| full | output | 1 | Buffer holds 15 words (write domain) |
| empty | output | 1 | Buffer holds no word (read domain) |
| start_rd_n | output | 1 | One-shot start-read strobe, active low (write domain) |

## Verification
The hardest case is showing that the strobe never fires a second time. This needs a strobe that has already completed its low pulse, followed by a drain to empty and a refill back to five words. The write side must also have seen the read pointer come back through the synchronizer. The stimulus produces the pulse, reads every word, waits out the synchronizer latency and rewrites five words. It then watches the strobe over many write cycles. A reset through each of the other two reset inputs follows, and the strobe is expected to fire again after each.

// File: rtl/xclk_startbuf_pkg.sv
package xclk_startbuf_pkg;

  localparam int unsigned DEF_DATA_W   = 10;
  localparam int unsigned DEF_DEPTH    = 15;
  localparam int unsigned DEF_HALF_LVL = 5;
  localparam int unsigned DEF_SYNC_STG = 2;

  typedef enum logic [1:0] {
    STRB_ARMED  = 2'd0,
    STRB_ACTIVE = 2'd1,
    STRB_SPENT  = 2'd2
  } strb_state_e;

endpackage

// File: rtl/xsb_rst_sync.sv
module xsb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = shift_q[STAGES-1];

endmodule

// File: rtl/xsb_bus_sync.sv
module xsb_bus_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/xsb_wr_side.sv
module xsb_wr_side
  import xclk_startbuf_pkg::*;
#(
  parameter int unsigned DEPTH    = DEF_DEPTH,
  parameter int unsigned PTR_W    = 5,
  parameter int unsigned HALF_LVL = DEF_HALF_LVL
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] rgray_sync,
  output logic [PTR_W-1:0] wptr_bin,
  output logic [PTR_W-1:0] wptr_gray,
  output logic [PTR_W-1:0] occ,
  output logic             full,
  output logic             wr_fire,
  output logic             start_rd_n
);

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] LOW_AT  = PTR_W'(HALF_LVL);
  localparam logic [PTR_W-1:0] HIGH_AT = PTR_W'(HALF_LVL + 1);

  logic [PTR_W-1:0] rbin_sync;
  logic [PTR_W-1:0] wptr_nxt;
  strb_state_e      strb_q, strb_d;

  always_comb begin
    rbin_sync[PTR_W-1] = rgray_sync[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      rbin_sync[i] = rbin_sync[i+1] ^ rgray_sync[i];
    end
  end

  assign occ     = wptr_bin - rbin_sync;
  assign full    = (occ >= DEPTH_P);
  assign wr_fire = wr_en && !full;

  always_comb begin
    wptr_nxt = wptr_bin;
    if (wr_fire) wptr_nxt = wptr_bin + 1'b1;
  end

  always_comb begin
    strb_d = strb_q;
    unique case (strb_q)
      STRB_ARMED:  if (occ >= LOW_AT)  strb_d = STRB_ACTIVE;
      STRB_ACTIVE: if (occ >= HIGH_AT) strb_d = STRB_SPENT;
      STRB_SPENT:  strb_d = STRB_SPENT;
      default:     strb_d = STRB_SPENT;
    endcase
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
      strb_q    <= STRB_ARMED;
    end else begin
      wptr_bin  <= wptr_nxt;
      wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      strb_q    <= strb_d;
    end
  end

  assign start_rd_n = (strb_q != STRB_ACTIVE);

endmodule

// File: rtl/xsb_rd_side.sv
module xsb_rd_side #(
  parameter int unsigned PTR_W = 5
) (
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_en,
  input  logic [PTR_W-1:0] wgray_sync,
  output logic [PTR_W-1:0] rptr_bin,
  output logic [PTR_W-1:0] rptr_gray,
  output logic             empty,
  output logic             rd_fire
);

  logic [PTR_W-1:0] wbin_sync;
  logic [PTR_W-1:0] rptr_nxt;

  always_comb begin
    wbin_sync[PTR_W-1] = wgray_sync[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      wbin_sync[i] = wbin_sync[i+1] ^ wgray_sync[i];
    end
  end

  assign empty   = (rptr_bin == wbin_sync);
  assign rd_fire = rd_en && !empty;

  always_comb begin
    rptr_nxt = rptr_bin;
    if (rd_fire) rptr_nxt = rptr_bin + 1'b1;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
    end else begin
      rptr_bin  <= rptr_nxt;
      rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
    end
  end

endmodule

// File: rtl/xclk_startbuf.sv
module xclk_startbuf
  import xclk_startbuf_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned DEPTH    = DEF_DEPTH,
  parameter int unsigned HALF_LVL = DEF_HALF_LVL,
  parameter int unsigned SYNC_STG = DEF_SYNC_STG
) (
  input  logic              wclk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rd_en,
  input  logic              por_n,
  input  logic              buf_rst_n,
  input  logic              glob_rst_n,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty,
  output logic              start_rd_n
);

  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned PTR_W  = ADDR_W + 1;
  localparam int unsigned SLOTS  = 1 << ADDR_W;

  logic              any_rst_n;
  logic              wrst_n, rrst_n;
  logic [PTR_W-1:0]  wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PTR_W-1:0]  wgray_sync, rgray_sync, occ;
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] store_q [SLOTS];
  logic [DATA_W-1:0] rdata_d;

  assign any_rst_n = por_n & buf_rst_n & glob_rst_n;

  xsb_rst_sync #(.STAGES(SYNC_STG)) u_wrst (
    .clk(wclk), .arst_n(any_rst_n), .srst_n(wrst_n)
  );

  xsb_rst_sync #(.STAGES(SYNC_STG)) u_rrst (
    .clk(rclk), .arst_n(any_rst_n), .srst_n(rrst_n)
  );

  xsb_bus_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STG)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rptr_gray), .q(rgray_sync)
  );

  xsb_bus_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STG)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wptr_gray), .q(wgray_sync)
  );

  xsb_wr_side #(.DEPTH(DEPTH), .PTR_W(PTR_W), .HALF_LVL(HALF_LVL)) u_wr (
    .wclk       (wclk),
    .wrst_n     (wrst_n),
    .wr_en      (wr_en),
    .rgray_sync (rgray_sync),
    .wptr_bin   (wptr_bin),
    .wptr_gray  (wptr_gray),
    .occ        (occ),
    .full       (full),
    .wr_fire    (wr_fire),
    .start_rd_n (start_rd_n)
  );

  xsb_rd_side #(.PTR_W(PTR_W)) u_rd (
    .rclk       (rclk),
    .rrst_n     (rrst_n),
    .rd_en      (rd_en),
    .wgray_sync (wgray_sync),
    .rptr_bin   (rptr_bin),
    .rptr_gray  (rptr_gray),
    .empty      (empty),
    .rd_fire    (rd_fire)
  );

  // Storage: written in the write domain only, no reset needed.
  always_ff @(posedge wclk) begin
    if (wr_fire) store_q[wptr_bin[ADDR_W-1:0]] <= wdata;
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_fire) rdata_d = store_q[rptr_bin[ADDR_W-1:0]];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rdata <= '0;
    else         rdata <= rdata_d;
  end

endmodule

// File: rtl/xclk_startbuf_chk.sv
module xclk_startbuf_chk #(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned PTR_W    = 5,
  parameter int unsigned HALF_LVL = 5
) (
  input logic              wclk,
  input logic              rclk,
  input logic              wrst_n,
  input logic              rrst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full,
  input logic              empty,
  input logic              start_rd_n,
  input logic [PTR_W-1:0]  wptr_bin,
  input logic [PTR_W-1:0]  rptr_bin,
  input logic [PTR_W-1:0]  wptr_gray,
  input logic [PTR_W-1:0]  occ,
  input logic [DATA_W-1:0] rdata
);

  localparam logic [PTR_W-1:0] LOW_AT = PTR_W'(HALF_LVL);

  // R2
  gray_one_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  // R3
  no_write_when_full_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> $stable(wptr_bin));

  // R4
  no_read_when_empty_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> $stable(rptr_bin));

  // R5
  strobe_fall_level_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $fell(start_rd_n) |-> ($past(occ) >= LOW_AT));

  // R7
  strobe_stays_high_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $rose(start_rd_n) |=> start_rd_n);

  // R9
  rdata_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !(rd_en && !empty) |=> $stable(rdata));

endmodule

bind xclk_startbuf xclk_startbuf_chk #(
  .DATA_W(DATA_W), .PTR_W(PTR_W), .HALF_LVL(HALF_LVL)
) u_chk (
  .wclk       (wclk),
  .rclk       (rclk),
  .wrst_n     (wrst_n),
  .rrst_n     (rrst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .full       (full),
  .empty      (empty),
  .start_rd_n (start_rd_n),
  .wptr_bin   (wptr_bin),
  .rptr_bin   (rptr_bin),
  .wptr_gray  (wptr_gray),
  .occ        (occ),
  .rdata      (rdata)
);

// File: tb/sim_xclk_startbuf.sv
`timescale 1ns/1ps
module sim_xclk_startbuf;

  logic       wclk = 1'b0;
  logic       rclk = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [9:0] wdata = '0;
  logic       por_n = 1'b0;
  logic       buf_rst_n = 1'b0;
  logic       glob_rst_n = 1'b0;
  logic [9:0] rdata;
  logic       full, empty, start_rd_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 wclk = ~wclk;   // 50 MHz
  always #13 rclk = ~rclk;

  xclk_startbuf u0 (
    .wclk(wclk), .wr_en(wr_en), .wdata(wdata),
    .rclk(rclk), .rd_en(rd_en),
    .por_n(por_n), .buf_rst_n(buf_rst_n), .glob_rst_n(glob_rst_n),
    .rdata(rdata), .full(full), .empty(empty), .start_rd_n(start_rd_n)
  );

  localparam int NVEC = 8;
  localparam logic [9:0] VEC [NVEC] = '{
    10'h001, 10'h3FF, 10'h2AA, 10'h155, 10'h000, 10'h200, 10'h0F0, 10'h30C
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] d);
    @(negedge wclk); wr_en = 1'b1; wdata = d;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic do_read();
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge wclk);
    repeat (5) @(negedge rclk);
  endtask

  task automatic check_idle(input string req);
    check(empty == 1'b1, req, empty, 1);
    check(full == 1'b0, req, full, 0);
    check(start_rd_n == 1'b1, req, start_rd_n, 1);
    check(rdata == 10'h000, req, rdata, 0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: state while held in reset and after release
    #45;
    check_idle("R1 in reset");
    por_n = 1'b1; buf_rst_n = 1'b1; glob_rst_n = 1'b1;
    settle();
    check_idle("R1 after release");

    // R2: table of words, written then read back in order
    for (int i = 0; i < NVEC; i++) do_write(VEC[i]);
    settle();
    check(empty == 1'b0, "R2 not empty", empty, 0);
    for (int i = 0; i < NVEC; i++) begin
      do_read();
      check(rdata == VEC[i], "R2 order", rdata, VEC[i]);
    end
    settle();
    check(empty == 1'b1, "R4 empty after drain", empty, 1);

    // R8 via buf_rst_n, then R6 back-to-back one-cycle pulse
    @(negedge wclk); buf_rst_n = 1'b0; #30; buf_rst_n = 1'b1;
    settle();
    check_idle("R8 buf_rst_n");
    @(negedge wclk); wr_en = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      wdata = 10'(i);
      @(negedge wclk);
      if (i == 6) wr_en = 1'b0;
      check(start_rd_n == ((i == 6) ? 1'b0 : 1'b1), "R6 pulse", start_rd_n, (i == 6) ? 0 : 1);
    end

    // R7: drain, refill to five, strobe stays high
    settle();
    for (int i = 1; i <= 6; i++) begin
      do_read();
      check(rdata == 10'(i), "R2 burst data", rdata, i);
    end
    settle();
    for (int i = 0; i < 5; i++) do_write(10'h100 + 10'(i));
    begin
      bit stayed = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge wclk);
        if (start_rd_n !== 1'b1) stayed = 1'b0;
      end
      check(stayed, "R7 no refire", stayed, 1);
    end

    // R8 via glob_rst_n, then R5 held low at five words
    @(negedge wclk); glob_rst_n = 1'b0; #30; glob_rst_n = 1'b1;
    settle();
    check_idle("R8 glob_rst_n");
    for (int i = 0; i < 5; i++) do_write(10'h050 + 10'(i));
    check(start_rd_n == 1'b1, "R5 not yet", start_rd_n, 1);
    @(negedge wclk);
    check(start_rd_n == 1'b0, "R5 low at five", start_rd_n, 0);
    repeat (3) @(negedge wclk);
    check(start_rd_n == 1'b0, "R5 held low", start_rd_n, 0);
    do_write(10'h055);
    check(start_rd_n == 1'b0, "R6 still low", start_rd_n, 0);
    @(negedge wclk);
    check(start_rd_n == 1'b1, "R6 high at six", start_rd_n, 1);

    // R8 via por_n, then R3 full and dropped write
    @(negedge wclk); por_n = 1'b0; #30; por_n = 1'b1;
    settle();
    check_idle("R8 por_n");
    for (int i = 0; i < 15; i++) begin
      do_write(10'h200 + 10'(i));
      if (i == 13) check(full == 1'b0, "R3 not full at 14", full, 0);
    end
    check(full == 1'b1, "R3 full at 15", full, 1);
    do_write(10'h3EE);
    check(full == 1'b1, "R3 still full", full, 1);
    settle();
    for (int i = 0; i < 15; i++) begin
      do_read();
      check(rdata == 10'h200 + 10'(i), "R3 contents", rdata, 10'h200 + 10'(i));
    end
    settle();
    check(empty == 1'b1, "R4 empty after 15", empty, 1);
    check(full == 1'b0, "R3 full clears", full, 0);

    // R4 / R9: read while empty is dropped, rdata holds
    do_read();
    check(rdata == 10'h20E, "R9 hold on empty read", rdata, 10'h20E);
    do_write(10'h1A5);
    settle();
    repeat (3) @(negedge rclk);
    check(rdata == 10'h20E, "R9 hold without rd_en", rdata, 10'h20E);
    do_read();
    check(rdata == 10'h1A5, "R4 pointer unchanged", rdata, 10'h1A5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule